// File: doc/BRIEF.md
# Serial Slave Register Port

This block is the slave end of a three-wire synchronous serial link. A host drives a select line, a serial clock and a data-in line, and reads back on a data-out line. Through this link the host reaches a 128-location byte space on the chip's parallel side. That space holds a general-purpose RAM region and a timekeeping register region. The register contents live outside this block. The port only produces address, write data and single-cycle strobes, and it accepts read data back in the same cycle.

Each transaction opens when select is asserted. The first byte names a location and a direction. Every byte after it is data for successive locations until select drops, and the location advances after each byte. The idle level of the serial clock is taken from the moment select is asserted, so hosts of either clock polarity work without setup. While a transaction is open the block raises an access flag, which lets the timekeeper hold its counters steady. A power-down input shuts the port off entirely.

All serial inputs are synchronised into the system clock domain. Each serial clock half-period must therefore last at least five system clock cycles.

Top module: `sps_serial_port`

## Requirements
- R1: After reset `miso_oe`, `access_active`, `reg_we` and `reg_re` are all low.
- R2: The first byte of a transaction is the address byte. It is shifted most significant bit first. Bit 7 = 1 selects a write and 0 selects a read, and bits 6:0 give the starting index.
- R3: In a write transaction each complete data byte produces exactly one single-cycle `reg_we` pulse. The pulse carries `reg_addr` = current index and `reg_wdata` = the byte, and the index advances after the pulse.
- R4: In a read transaction the index is read with a single-cycle `reg_re` pulse after the address byte and again after each data byte, with the index advancing each time. The bytes shifted out MSB first on `miso_o` equal `reg_rdata` of the successive indexes.
- R5: Index advance wraps inside its region. RAM covers 0x00..0x1F and goes 0x1F→0x00. Registers cover 0x20..0x32 and go 0x32→0x20. Any other index raises no strobe, reads as 0x00, and advances by one modulo 128.
- R6: The level of `sck` when select asserts is the idle level. `mosi` is sampled on the edge returning to idle, and `miso_o` changes on the edge leaving idle. Both idle levels work identically.
- R7: A new address needs select to be released and asserted again. A byte cut short by release of select raises no strobe.
- R8: `miso_oe` is high only while selected in a read transaction after its address byte. It is low throughout write transactions and while deselected.
- R9: `access_active` is high while select is asserted and low after it is released. The synchroniser adds a delay of three system clocks.
- R10: While `pwr_down` is high the port ignores select. No strobes are raised, and `access_active` and `miso_oe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| sel | input | 1 | Active-high slave select |
| pwr_down | input | 1 | Disables the port while high |
| miso_o | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the data-out pad |
| access_active | output | 1 | Transaction open, lets timekeeping freeze |
| reg_we | output | 1 | Write strobe to register/RAM space |
| reg_re | output | 1 | Read strobe to register/RAM space |
| reg_addr | output | 7 | Location index |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the `reg_re` cycle |

## Verification
Random transactions mix both clock idle levels, both directions, burst lengths of one to five bytes, and start indexes spread over the RAM, register and unmapped regions. A wrong bit order, a wrong edge choice or a broken increment therefore shows up as a specific wrong byte or location. Directed bursts start one byte before each region end, which separates correct wrap from plain modulo-128 counting. A read from an unmapped index separates "no strobe, zero data" from a stray access. A byte cut short by deselect, and a whole transaction attempted under power-down, show whether partial or disabled traffic leaks into a strobe, the output enable or the access flag.

// File: rtl/sps_pkg.sv
// Shared constants and types for the serial slave register port.
// Assumes byte-wide transfers with one direction bit in the address byte.
package sps_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/sps_sync.sv
// Multi-bit input synchroniser, one independent flop chain per bit.
// Assumes each bit is a slow level with no relation to the others.
module sps_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (STAGES == 1) begin : g_one
            logic flop;
            // single stage capture
            always_ff @(posedge clk) begin
                if (!rst_n) flop <= 1'b0;
                else        flop <= d[g];
            end
            assign q[g] = flop;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            // shift the input through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d[g]};
            end
            assign q[g] = chain[STAGES-1];
        end
    end
endmodule

// File: rtl/sps_bit_engine.sv
// Serial framing: learns the idle clock level at select, finds leading and
// trailing edges, and assembles received bytes MSB first.
// Assumes synchronised inputs and at least five system clocks per SCK half.
module sps_bit_engine
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sel_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    output logic              sel_now,
    output logic              sel_on,
    output logic              sel_start,
    output logic              lead,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    logic             sel_q;
    logic             sck_q;
    logic             idle_lvl;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-2:0] shreg;
    logic             live;
    logic             moved;
    logic             trail;

    assign sel_now   = sel_s & en;
    assign sel_on    = sel_q;
    assign sel_start = sel_now & ~sel_q;
    assign live      = sel_now & sel_q;
    assign moved     = sck_s ^ sck_q;
    assign lead      = live & moved & (sck_s != idle_lvl);
    assign trail     = live & moved & (sck_s == idle_lvl);
    assign byte_done = trail & (cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte   = {shreg, mosi_s};

    // select and clock history, idle level capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            sck_q    <= 1'b0;
            idle_lvl <= 1'b0;
        end else begin
            sel_q <= sel_now;
            sck_q <= sck_s;
            if (sel_start) idle_lvl <= sck_s;
        end
    end

    // bit counter and receive shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (!live) begin
            cnt   <= '0;
        end else if (trail) begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[BYTE_W-3:0], mosi_s};
        end
    end
endmodule

// File: rtl/sps_index_map.sv
// Region decode and next-index rule for the location space.
// Assumes the RAM region starts at zero and the register region sits above it.
module sps_index_map
    import sps_pkg::*;
#(
    parameter int RAM_DEPTH = 32,
    parameter int REG_BASE  = 32,
    parameter int REG_COUNT = 19
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt,
    output logic             mapped
);
    localparam int RAM_LAST = RAM_DEPTH - 1;
    localparam int REG_LAST = REG_BASE + REG_COUNT - 1;
    localparam logic [IDX_W-1:0] REG_FIRST_V = IDX_W'(REG_BASE);

    logic in_ram;
    logic in_reg;
    int   ival;

    // region membership and wrap-aware successor
    always_comb begin
        ival   = int'(idx);
        in_ram = ival <= RAM_LAST;
        in_reg = (ival >= REG_BASE) && (ival <= REG_LAST);
        mapped = in_ram | in_reg;
        if (in_ram && ival == RAM_LAST)      nxt = '0;
        else if (in_reg && ival == REG_LAST) nxt = REG_FIRST_V;
        else                                 nxt = idx + 1'b1;
    end
endmodule

// File: rtl/sps_tx_shift.sv
// Transmit shifter: loads a byte, presents one bit per leading edge, MSB first.
// Assumes a load never coincides with a leading edge.
module sps_tx_shift
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              lead,
    output logic              miso
);
    logic [BYTE_W-1:0] tx;

    // load, shift and present the outgoing bit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tx   <= '0;
            miso <= 1'b0;
        end else if (load) begin
            tx   <= load_val;
        end else if (lead) begin
            miso <= tx[BYTE_W-1];
            tx   <= {tx[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sps_serial_port.sv
// Serial slave register port top. Decodes the address byte, runs bursts with
// auto-increment, and drives single-cycle strobes to the parallel side.
// Assumes reg_rdata is valid combinationally in the cycle reg_re is high.
module sps_serial_port
    import sps_pkg::*;
#(
    parameter int RAM_DEPTH   = 32,
    parameter int REG_BASE    = 32,
    parameter int REG_COUNT   = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              sel,
    input  logic              pwr_down,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              access_active,
    output logic              reg_we,
    output logic              reg_re,
    output logic [IDX_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic [2:0]        pins_s;
    logic              sel_now;
    logic              sel_on;
    logic              sel_start;
    logic              lead;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [IDX_W-1:0]  idx_nxt;
    logic              idx_mapped;

    phase_e            phase_q;
    logic              is_wr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              rd_req_q;
    logic              wr_req_q;
    logic [BYTE_W-1:0] wbuf_q;
    logic              en;

    assign en = ~pwr_down;

    sps_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel, sck, mosi}),
        .q     (pins_s)
    );

    sps_bit_engine u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sel_s     (pins_s[2]),
        .sck_s     (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .sel_now   (sel_now),
        .sel_on    (sel_on),
        .sel_start (sel_start),
        .lead      (lead),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    sps_index_map #(
        .RAM_DEPTH (RAM_DEPTH),
        .REG_BASE  (REG_BASE),
        .REG_COUNT (REG_COUNT)
    ) u_map (
        .idx    (idx_q),
        .nxt    (idx_nxt),
        .mapped (idx_mapped)
    );

    sps_tx_shift u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (~sel_now),
        .load     (rd_req_q),
        .load_val (idx_mapped ? reg_rdata : '0),
        .lead     (lead),
        .miso     (miso_o)
    );

    // transaction sequencing: address byte, then data bytes with advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            is_wr_q  <= 1'b0;
            idx_q    <= '0;
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
            wbuf_q   <= '0;
        end else if (!sel_now) begin
            phase_q  <= PH_IDLE;
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
        end else begin
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
            if (sel_start) phase_q <= PH_ADDR;
            if (wr_req_q)  idx_q   <= idx_nxt;
            if (byte_done) begin
                case (phase_q)
                    PH_ADDR: begin
                        idx_q    <= rx_byte[IDX_W-1:0];
                        is_wr_q  <= rx_byte[BYTE_W-1];
                        rd_req_q <= ~rx_byte[BYTE_W-1];
                        phase_q  <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (is_wr_q) begin
                            wbuf_q   <= rx_byte;
                            wr_req_q <= 1'b1;
                        end else begin
                            idx_q    <= idx_nxt;
                            rd_req_q <= 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign access_active = sel_on;
    assign miso_oe       = sel_on & (phase_q == PH_DATA) & ~is_wr_q;
    assign reg_addr      = idx_q;
    assign reg_wdata     = wbuf_q;
    assign reg_we        = wr_req_q & idx_mapped & en;
    assign reg_re        = rd_req_q & idx_mapped & en;
endmodule

// File: rtl/sps_serial_port_chk.sv
// Protocol checker for the serial slave register port, bound to the top.
// Assumes the same region parameters as the instance it watches.
module sps_serial_port_chk
    import sps_pkg::*;
#(
    parameter int RAM_DEPTH = 32,
    parameter int REG_BASE  = 32,
    parameter int REG_COUNT = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_down,
    input logic             miso_oe,
    input logic             access_active,
    input logic             reg_we,
    input logic             reg_re,
    input logic [IDX_W-1:0] reg_addr
);
    logic addr_ok;
    assign addr_ok = (int'(reg_addr) < RAM_DEPTH) ||
                     ((int'(reg_addr) >= REG_BASE) && (int'(reg_addr) < REG_BASE + REG_COUNT));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_re_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);
    assert_strobe_mapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> addr_ok);
    assert_open_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_active) |-> (!miso_oe && !reg_we && !reg_re));
    assert_oe_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> access_active);
    assert_pd_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!reg_we && !reg_re));
    assert_pd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> (!access_active && !miso_oe));
endmodule

bind sps_serial_port sps_serial_port_chk #(
    .RAM_DEPTH (RAM_DEPTH),
    .REG_BASE  (REG_BASE),
    .REG_COUNT (REG_COUNT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_down      (pwr_down),
    .miso_oe       (miso_oe),
    .access_active (access_active),
    .reg_we        (reg_we),
    .reg_re        (reg_re),
    .reg_addr      (reg_addr)
);

// File: tb/sim_sps_serial_port.sv
// Bench: host-side serial driver, a 128-byte location model on the parallel
// side, random and directed transactions checked against computed values.
module sim_sps_serial_port;
    localparam int HALF = 8;

    logic       clk;
    logic       rst_n;
    logic       sck;
    logic       mosi;
    logic       sel;
    logic       pwr_down;
    logic       miso_o;
    logic       miso_oe;
    logic       access_active;
    logic       reg_we;
    logic       reg_re;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    logic [7:0] mem [128];
    logic [7:0] burst [8];
    int         wr_count;
    int         n_vec;
    int         n_bad;
    logic       idle;
    logic       done;

    sps_serial_port u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck           (sck),
        .mosi          (mosi),
        .sel           (sel),
        .pwr_down      (pwr_down),
        .miso_o        (miso_o),
        .miso_oe       (miso_oe),
        .access_active (access_active),
        .reg_we        (reg_we),
        .reg_re        (reg_re),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 37 + 11);
            wr_count <= 0;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wr_count      <= wr_count + 1;
        end
    end

    function automatic logic f_mapped(input logic [6:0] a);
        return (a <= 7'h32);
    endfunction

    function automatic logic [6:0] f_next(input logic [6:0] a);
        if (a == 7'h1F)      return 7'h00;
        else if (a == 7'h32) return 7'h20;
        else                 return a + 7'd1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic byte_xfer(input logic [7:0] t, output logic [7:0] r,
                             output logic oe_any, output logic oe_all);
        oe_any = 1'b0;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck  = ~idle;
            mosi = t[i];
            half_wait();
            r[i]   = miso_o;
            oe_any = oe_any | miso_oe;
            oe_all = oe_all & miso_oe;
            sck    = idle;
            half_wait();
        end
    endtask

    task automatic begin_txn(input logic exp_act);
        sck = idle;
        repeat (4) @(negedge clk);
        sel = 1'b1;
        repeat (6) @(negedge clk);
        check("R9", "access_active while selected", access_active, exp_act);
    endtask

    task automatic end_txn();
        repeat (6) @(negedge clk);
        sel = 1'b0;
        repeat (8) @(negedge clk);
        check("R9", "access_active after release", access_active, 1'b0);
        check("R8", "miso_oe after release", miso_oe, 1'b0);
    endtask

    task automatic do_write(input logic cp, input logic [6:0] idx, input int len);
        logic [7:0] r;
        logic       oa, ol, any_oe;
        logic [6:0] a;
        int         wc0, nmap;
        idle   = cp;
        wc0    = wr_count;
        any_oe = 1'b0;
        begin_txn(1'b1);
        byte_xfer({1'b1, idx}, r, oa, ol);
        any_oe = any_oe | oa;
        for (int k = 0; k < len; k++) begin
            byte_xfer(burst[k], r, oa, ol);
            any_oe = any_oe | oa;
        end
        end_txn();
        check("R8", "miso_oe during write", any_oe, 1'b0);
        a    = idx;
        nmap = 0;
        for (int k = 0; k < len; k++) begin
            if (f_mapped(a)) begin
                nmap++;
                check("R3", $sformatf("write byte %0d at %0h", k, a), mem[a], burst[k]);
            end
            a = f_next(a);
        end
        check("R5", "write strobe count", wr_count - wc0, nmap);
    endtask

    task automatic do_read(input logic cp, input logic [6:0] idx, input int len);
        logic [7:0] r, e;
        logic       oa, ol;
        logic [6:0] a;
        idle = cp;
        begin_txn(1'b1);
        byte_xfer({1'b0, idx}, r, oa, ol);
        check("R8", "miso_oe during read address byte", oa, 1'b0);
        a = idx;
        for (int k = 0; k < len; k++) begin
            e = f_mapped(a) ? mem[a] : 8'h00;
            byte_xfer(8'h00, r, oa, ol);
            check("R4", $sformatf("read byte %0d at %0h", k, a), r, e);
            check("R8", "miso_oe during read data", ol, 1'b1);
            a = f_next(a);
        end
        end_txn();
    endtask

    initial begin : watchdog
        done = 1'b0;
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL all: watchdog actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        logic       oa, ol;
        int         wc0;
        logic [7:0] keep;
        n_vec    = 0;
        n_bad    = 0;
        rst_n    = 1'b0;
        sck      = 1'b0;
        mosi     = 1'b0;
        sel      = 1'b0;
        pwr_down = 1'b0;
        idle     = 1'b0;
        void'($urandom(32'd4821));
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1", "miso_oe in reset", miso_oe, 1'b0);
        check("R1", "access_active in reset", access_active, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "strobes after reset", {reg_we, reg_re}, 2'b00);
        check("R1", "miso_oe after reset", miso_oe, 1'b0);

        // R2 direction bit and MSB-first order, both idle levels (R6)
        burst[0] = 8'hA1; burst[1] = 8'h3C;
        do_write(1'b0, 7'h05, 2);
        do_read(1'b1, 7'h05, 2);
        check("R2", "msb-first round trip", mem[7'h05], 8'hA1);
        burst[0] = 8'h96;
        do_write(1'b1, 7'h21, 1);
        do_read(1'b0, 7'h21, 1);
        check("R6", "idle-high write seen", mem[7'h21], 8'h96);

        // R5 wrap at region ends and unmapped reads
        burst[0] = 8'h11; burst[1] = 8'h22; burst[2] = 8'h33; burst[3] = 8'h44;
        do_write(1'b0, 7'h1E, 4);
        check("R5", "RAM wrap to 00", mem[7'h00], 8'h33);
        do_read(1'b1, 7'h31, 4);
        do_read(1'b0, 7'h7E, 3);

        // R7 partial byte discarded on release
        wc0  = wr_count;
        keep = mem[7'h03];
        idle = 1'b0;
        begin_txn(1'b1);
        byte_xfer(8'h83, r, oa, ol);
        for (int i = 7; i >= 4; i--) begin
            sck = 1'b1; mosi = 1'b1; half_wait();
            sck = 1'b0; half_wait();
        end
        end_txn();
        check("R7", "no strobe for cut byte", wr_count - wc0, 0);
        check("R7", "location unchanged", mem[7'h03], keep);

        // R10 power-down ignores a full write and read
        pwr_down = 1'b1;
        wc0  = wr_count;
        keep = mem[7'h06];
        idle = 1'b1;
        begin_txn(1'b0);
        byte_xfer(8'h86, r, oa, ol);
        byte_xfer(8'h5A, r, oa, ol);
        check("R10", "miso_oe under power-down", oa, 1'b0);
        end_txn();
        check("R10", "no write under power-down", wr_count - wc0, 0);
        check("R10", "location kept", mem[7'h06], keep);
        begin_txn(1'b0);
        byte_xfer(8'h06, r, oa, ol);
        byte_xfer(8'h00, r, oa, ol);
        check("R10", "no output enable on read", oa, 1'b0);
        end_txn();
        pwr_down = 1'b0;
        repeat (4) @(negedge clk);

        // random mix over regions, directions, idle levels and lengths
        for (int n = 0; n < 40; n++) begin
            logic       cp, wr;
            logic [6:0] ix;
            int         len, pick;
            cp   = 1'($urandom % 2);
            wr   = 1'($urandom % 2);
            pick = int'($urandom % 8);
            if (pick < 4)      ix = 7'($urandom % 32);
            else if (pick < 7) ix = 7'(32 + $urandom % 19);
            else               ix = 7'(51 + $urandom % 77);
            len = 1 + int'($urandom % 5);
            for (int k = 0; k < 8; k++) burst[k] = 8'($urandom);
            if (wr) do_write(cp, ix, len);
            else    do_read(cp, ix, len);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule